// File: doc/BRIEF.md
# Counter Loop Branch Execute Unit

This execute-stage unit runs one three-byte loop instruction. The first byte is a fixed opcode. The second is a packed control byte, and the third is the low byte of a branch displacement. The control byte selects one of six counters: two 8-bit accumulators (A, B) and four 16-bit registers (D, X, Y, SP). It also selects what to do with that counter: leave it alone, decrement it, or increment it. The unit then tests the resulting value against zero and branches when the test matches the chosen sense (zero or nonzero).

The surrounding pipeline places the instruction PC, the three bytes and the current register-file read values on the inputs and pulses `start`. After a fixed three-cycle latency the unit presents:
- the next PC,
- the counter's new value, with its register code and a write strobe,
- an illegal-operation flag.

Condition-code flags are not an input or an output of this unit, so the instruction cannot change them.

Top module: `cbu_top`

## Requirements
- R1: The opcode byte must equal 0x04. Any other opcode raises `illegal`, suppresses the write, and gives next PC = PC + 3.
- R2: Control byte bits 2:0 choose the counter, and `wr_sel` echoes them. The codes are 000=A, 001=B, 100=D, 101=X, 110=Y and 111=SP. Codes 010 and 011 raise `illegal` with no write.
- R3: Control byte bits 7:6 choose the operation: 01 tests only, 00 decrements then tests, 10 increments then tests. `wr_en` pulses only for 00 and 10, and only in the result cycle.
- R4: Control byte bits 7:6 = 11 raises `illegal`. In that case `wr_en` stays low and next PC = PC + 3.
- R5: Control byte bit 5 sets the branch sense. When it is 0 the branch is taken if the tested value is zero; when it is 1 the branch is taken if the value is nonzero.
- R6: Control byte bit 4 is the sign of a 9-bit offset whose low 8 bits are the third byte, giving a range of -256 to +255. A taken branch gives next PC = PC + 3 + offset, modulo 2^16.
- R7: Control byte bit 3 has no effect on any output.
- R8: A and B wrap within 8 bits, and `wr_data[15:8]` is 0 for them. D, X, Y and SP wrap within 16 bits.
- R9: The zero test uses the value after the update, at the counter's own width.
- R10: `done` goes high for one cycle on the third rising edge, counting the edge that samples `start`. `busy` is high in between, and `start` is ignored while `busy` is high.
- R11: A branch that is not taken gives next PC = PC + 3, modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept the instruction on the inputs |
| pc_in | input | 16 | Address of the instruction's first byte |
| opc_byte | input | 8 | Opcode byte |
| ctl_byte | input | 8 | Packed control byte |
| disp_byte | input | 8 | Low 8 bits of the displacement |
| rd_a | input | 8 | Accumulator A value |
| rd_b | input | 8 | Accumulator B value |
| rd_d | input | 16 | Register D value |
| rd_x | input | 16 | Register X value |
| rd_y | input | 16 | Register Y value |
| rd_sp | input | 16 | Stack pointer value |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | One-cycle result strobe |
| next_pc | output | 16 | Next program counter |
| wr_en | output | 1 | Counter write strobe |
| wr_sel | output | 3 | Register code to write |
| wr_data | output | 16 | Updated counter value |
| illegal | output | 1 | Illegal operation, opcode or register code |

## Verification
Every result (`next_pc`, `wr_en`, `wr_sel`, `wr_data`, `illegal`) appears with `done`, on the third rising edge counting the edge that samples `start`. The bench sets up each stimulus on a falling edge and waits three rising edges. It then samples the outputs on the following falling edge. It also checks that `done` is still low one edge earlier, so a result that arrives early or late is reported. `busy` is sampled on the falling edge after the first of those three rising edges.

// File: rtl/cbu_pkg.sv
// Shared types for the counter loop branch unit.
// Assumes: operation codes follow control byte bits 7:6.
package cbu_pkg;

    typedef enum logic [1:0] {
        OP_DEC  = 2'b00,
        OP_TEST = 2'b01,
        OP_INC  = 2'b10,
        OP_BAD  = 2'b11
    } cnt_op_t;

    typedef struct packed {
        cnt_op_t    op;
        logic       sense_nz;
        logic [2:0] sel;
        logic       sel_ok;
        logic       bad;
    } ctl_dec_t;

endpackage

// File: rtl/cbu_decode.sv
// Decodes the opcode and control byte into operation, branch sense,
// register code and sign-extended displacement.
// Assumes: bit 3 of the control byte carries no meaning.
module cbu_decode #(
    parameter int          PC_W   = 16,
    parameter logic [7:0]  OPCODE = 8'h04
) (
    input  logic [7:0]              opc,
    input  logic [7:0]              ctl,
    input  logic [7:0]              disp,
    output cbu_pkg::ctl_dec_t       dec,
    output logic signed [PC_W-1:0]  offset
);
    import cbu_pkg::*;

    localparam int EXT_W = PC_W - 9;

    // Field split, register-code check and illegal detection.
    always_comb begin
        dec.op       = cnt_op_t'(ctl[7:6]);
        dec.sense_nz = ctl[5];
        dec.sel      = ctl[2:0];
        dec.sel_ok   = (ctl[2:0] != 3'b010) && (ctl[2:0] != 3'b011);
        dec.bad      = (opc != OPCODE) || (ctl[7:6] == OP_BAD) || !dec.sel_ok;
    end

    // Nine-bit displacement: control bit 4 is the sign, then extended.
    always_comb begin
        offset = {{EXT_W{ctl[4]}}, ctl[4], disp};
    end
endmodule

// File: rtl/cbu_counter.sv
// Selects the counter, applies the test/decrement/increment operation
// at the counter's own width, and tests the result for zero.
// Assumes: codes with bit 2 set are wide registers, the rest narrow.
module cbu_counter #(
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16
) (
    input  cbu_pkg::cnt_op_t      op,
    input  logic [2:0]            sel,
    input  logic [NARROW_W-1:0]   a_val,
    input  logic [NARROW_W-1:0]   b_val,
    input  logic [WIDE_W-1:0]     d_val,
    input  logic [WIDE_W-1:0]     x_val,
    input  logic [WIDE_W-1:0]     y_val,
    input  logic [WIDE_W-1:0]     sp_val,
    output logic [WIDE_W-1:0]     new_val,
    output logic                  is_zero
);
    import cbu_pkg::*;

    localparam int PAD_W = WIDE_W - NARROW_W;

    logic [NARROW_W-1:0] n_cur, n_new;
    logic [WIDE_W-1:0]   w_cur, w_new;

    // Operand fetch for both widths.
    always_comb begin
        n_cur = sel[0] ? b_val : a_val;
        unique case (sel[1:0])
            2'b00:   w_cur = d_val;
            2'b01:   w_cur = x_val;
            2'b10:   w_cur = y_val;
            default: w_cur = sp_val;
        endcase
    end

    // Update at each width; wrap comes from the truncating adders.
    always_comb begin
        unique case (op)
            OP_DEC: begin
                n_new = n_cur - 1'b1;
                w_new = w_cur - 1'b1;
            end
            OP_INC: begin
                n_new = n_cur + 1'b1;
                w_new = w_cur + 1'b1;
            end
            default: begin
                n_new = n_cur;
                w_new = w_cur;
            end
        endcase
    end

    // Width choice and zero test on the updated value.
    always_comb begin
        if (sel[2]) begin
            new_val = w_new;
            is_zero = (w_new == '0);
        end else begin
            new_val = {{PAD_W{1'b0}}, n_new};
            is_zero = (n_new == '0);
        end
    end
endmodule

// File: rtl/cbu_target.sv
// Forms the fall-through and branch target addresses and picks one.
// Assumes: the instruction length is fixed; the PC wraps at its width.
module cbu_target #(
    parameter int PC_W    = 16,
    parameter int INSN_LEN = 3
) (
    input  logic [PC_W-1:0]         pc,
    input  logic signed [PC_W-1:0]  offset,
    input  logic                    taken,
    output logic [PC_W-1:0]         npc
);
    localparam logic [PC_W-1:0] LEN = PC_W'(INSN_LEN);

    logic [PC_W-1:0] seq_pc;

    // Sequential address, then optional displacement from it.
    always_comb begin
        seq_pc = pc + LEN;
        npc    = taken ? (seq_pc + PC_W'(offset)) : seq_pc;
    end
endmodule

// File: rtl/cbu_top.sv
// Counter loop branch execute unit. Captures one instruction on start,
// computes, and presents results with done on the third edge.
// Assumes: the register read values are valid in the start cycle.
module cbu_top #(
    parameter int         PC_W     = 16,
    parameter int         NARROW_W = 8,
    parameter int         WIDE_W   = 16,
    parameter int         LATENCY  = 3,
    parameter logic [7:0] OPCODE   = 8'h04
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [PC_W-1:0]     pc_in,
    input  logic [7:0]          opc_byte,
    input  logic [7:0]          ctl_byte,
    input  logic [7:0]          disp_byte,
    input  logic [NARROW_W-1:0] rd_a,
    input  logic [NARROW_W-1:0] rd_b,
    input  logic [WIDE_W-1:0]   rd_d,
    input  logic [WIDE_W-1:0]   rd_x,
    input  logic [WIDE_W-1:0]   rd_y,
    input  logic [WIDE_W-1:0]   rd_sp,
    output logic                busy,
    output logic                done,
    output logic [PC_W-1:0]     next_pc,
    output logic                wr_en,
    output logic [2:0]          wr_sel,
    output logic [WIDE_W-1:0]   wr_data,
    output logic                illegal
);
    import cbu_pkg::*;

    localparam int PH_W    = $clog2(LATENCY);
    localparam int LAST_PH = LATENCY - 1;

    logic [PH_W-1:0]      phase;
    logic [PC_W-1:0]      cap_pc;
    logic [7:0]           cap_opc, cap_ctl, cap_disp;
    logic [NARROW_W-1:0]  cap_a, cap_b;
    logic [WIDE_W-1:0]    cap_d, cap_x, cap_y, cap_sp;
    logic                 taken_q;

    ctl_dec_t                dec;
    logic signed [PC_W-1:0]  offset;
    logic [WIDE_W-1:0]       upd_val;
    logic                    upd_zero;
    logic                    take;
    logic [PC_W-1:0]         npc_c;

    assign busy = (phase != '0);

    // Phase sequencer: idle, then LATENCY-1 working cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (phase == '0) begin
            if (start) phase <= PH_W'(1);
        end else if (phase == PH_W'(LAST_PH)) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Operand capture on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_pc   <= '0;
            cap_opc  <= '0;
            cap_ctl  <= '0;
            cap_disp <= '0;
            cap_a    <= '0;
            cap_b    <= '0;
            cap_d    <= '0;
            cap_x    <= '0;
            cap_y    <= '0;
            cap_sp   <= '0;
        end else if (phase == '0 && start) begin
            cap_pc   <= pc_in;
            cap_opc  <= opc_byte;
            cap_ctl  <= ctl_byte;
            cap_disp <= disp_byte;
            cap_a    <= rd_a;
            cap_b    <= rd_b;
            cap_d    <= rd_d;
            cap_x    <= rd_x;
            cap_y    <= rd_y;
            cap_sp   <= rd_sp;
        end
    end

    cbu_decode #(.PC_W(PC_W), .OPCODE(OPCODE)) u_dec (
        .opc    (cap_opc),
        .ctl    (cap_ctl),
        .disp   (cap_disp),
        .dec    (dec),
        .offset (offset)
    );

    cbu_counter #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_cnt (
        .op      (dec.op),
        .sel     (dec.sel),
        .a_val   (cap_a),
        .b_val   (cap_b),
        .d_val   (cap_d),
        .x_val   (cap_x),
        .y_val   (cap_y),
        .sp_val  (cap_sp),
        .new_val (upd_val),
        .is_zero (upd_zero)
    );

    // Branch decision: sense selects zero or nonzero, illegal never branches.
    always_comb begin
        take = !dec.bad && (dec.sense_nz ? !upd_zero : upd_zero);
    end

    cbu_target #(.PC_W(PC_W), .INSN_LEN(3)) u_tgt (
        .pc     (cap_pc),
        .offset (offset),
        .taken  (take),
        .npc    (npc_c)
    );

    // Result registers, loaded in the last working phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            wr_en   <= 1'b0;
            next_pc <= '0;
            wr_sel  <= '0;
            wr_data <= '0;
            illegal <= 1'b0;
            taken_q <= 1'b0;
        end else if (phase == PH_W'(LAST_PH)) begin
            done    <= 1'b1;
            wr_en   <= !dec.bad && (dec.op != OP_TEST);
            next_pc <= npc_c;
            wr_sel  <= dec.sel;
            wr_data <= dec.bad ? '0 : upd_val;
            illegal <= dec.bad;
            taken_q <= take;
        end else begin
            done    <= 1'b0;
            wr_en   <= 1'b0;
        end
    end

    // R3: writes appear only in the result cycle.
    a_r3_write_in_result: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> done);

    // R4: an illegal result never writes.
    a_r4_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        illegal && done |-> !wr_en);

    // R10: the result strobe lasts one cycle.
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: the result follows a busy interval.
    a_r10_busy_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R11: fall-through target when the branch is not taken.
    a_r11_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        done && !taken_q |-> next_pc == cap_pc + PC_W'(3));

    // R8: narrow counters never set the upper result byte.
    a_r8_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done && !wr_sel[2] |-> wr_data[WIDE_W-1:NARROW_W] == '0);
endmodule

// File: tb/sim_cbu_top.sv
module sim_cbu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  opc_byte = '0, ctl_byte = '0, disp_byte = '0;
    logic [7:0]  rd_a = '0, rd_b = '0;
    logic [15:0] rd_d = '0, rd_x = '0, rd_y = '0, rd_sp = '0;
    logic        busy, done, wr_en, illegal;
    logic [15:0] next_pc, wr_data;
    logic [2:0]  wr_sel;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    cbu_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pc_in(pc_in),
        .opc_byte(opc_byte), .ctl_byte(ctl_byte), .disp_byte(disp_byte),
        .rd_a(rd_a), .rd_b(rd_b), .rd_d(rd_d), .rd_x(rd_x), .rd_y(rd_y),
        .rd_sp(rd_sp), .busy(busy), .done(done), .next_pc(next_pc),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .illegal(illegal)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference outcome derived from the requirements.
    task automatic model(output logic e_ill, output logic e_wr,
                         output logic [15:0] e_data, output logic [15:0] e_pc);
        logic [15:0] cur, nv, off;
        logic        wide, zero, tk;
        logic [2:0]  s;
        s     = ctl_byte[2:0];
        e_ill = (opc_byte != 8'h04) || (ctl_byte[7:6] == 2'b11) ||
                (s == 3'b010) || (s == 3'b011);
        wide  = s[2];
        case (s)
            3'b000: cur = {8'h00, rd_a};
            3'b001: cur = {8'h00, rd_b};
            3'b100: cur = rd_d;
            3'b101: cur = rd_x;
            3'b110: cur = rd_y;
            default: cur = rd_sp;
        endcase
        case (ctl_byte[7:6])
            2'b00:   nv = cur - 16'd1;
            2'b10:   nv = cur + 16'd1;
            default: nv = cur;
        endcase
        if (!wide) nv = {8'h00, nv[7:0]};
        zero  = (nv == 16'd0);
        tk    = !e_ill && (ctl_byte[5] ? !zero : zero);
        off   = {{8{ctl_byte[4]}}, disp_byte};
        e_pc  = tk ? pc_in + 16'd3 + off : pc_in + 16'd3;
        e_wr  = !e_ill && (ctl_byte[7:6] != 2'b01);
        e_data = e_ill ? 16'd0 : nv;
    endtask

    // Issue one instruction and check every result at its due cycle.
    task automatic run(input string req, input logic [15:0] pc,
                       input logic [7:0] op, input logic [7:0] ctl,
                       input logic [7:0] dsp);
        logic e_ill, e_wr;
        logic [15:0] e_data, e_pc;
        @(negedge clk);
        pc_in = pc; opc_byte = op; ctl_byte = ctl; disp_byte = dsp;
        model(e_ill, e_wr, e_data, e_pc);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R10", "busy", {31'd0, busy}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        chk("R10", "done early", {31'd0, done}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R10", "done", {31'd0, done}, 32'd1);
        chk(req, "next_pc", {16'd0, next_pc}, {16'd0, e_pc});
        chk(req, "illegal", {31'd0, illegal}, {31'd0, e_ill});
        chk(req, "wr_en", {31'd0, wr_en}, {31'd0, e_wr});
        chk("R2", "wr_sel", {29'd0, wr_sel}, {29'd0, ctl[2:0]});
        if (!e_ill) chk(req, "wr_data", {16'd0, wr_data}, {16'd0, e_data});
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R10", "reset done", {31'd0, done}, 32'd0);
        chk("R3", "reset wr_en", {31'd0, wr_en}, 32'd0);
        chk("R10", "reset busy", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_test_only;
        rd_a = 8'h00; rd_x = 16'h0005;
        run("R3", 16'h1000, 8'h04, 8'h40, 8'h10);  // A zero, branch on zero
        run("R5", 16'h1000, 8'h04, 8'h65, 8'h20);  // X nonzero, branch on nonzero
        run("R5", 16'h1000, 8'h04, 8'h45, 8'h20);  // X nonzero, no branch
    endtask

    task automatic t_dec_inc;
        rd_b = 8'h01; rd_d = 16'h0001; rd_y = 16'hFFFF; rd_sp = 16'h8000;
        run("R9", 16'h2000, 8'h04, 8'h01, 8'h08);  // B 1->0 branches
        run("R9", 16'h2000, 8'h04, 8'h24, 8'h08);  // D 1->0 nonzero sense: no branch
        run("R8", 16'h2000, 8'h04, 8'h86, 8'h08);  // Y FFFF->0 wraps, branches
        run("R3", 16'h2000, 8'h04, 8'hA7, 8'h08);  // SP increment
    endtask

    task automatic t_wrap8;
        rd_a = 8'hFF; rd_b = 8'h00;
        run("R8", 16'h3000, 8'h04, 8'h80, 8'h04);  // A FF->00
        run("R8", 16'h3000, 8'h04, 8'h21, 8'h04);  // B 00->FF nonzero
    endtask

    task automatic t_offsets;
        rd_a = 8'h00;
        run("R6", 16'h4000, 8'h04, 8'h50, 8'h00);  // -256
        run("R6", 16'h4000, 8'h04, 8'h40, 8'hFF);  // +255
        run("R6", 16'h0001, 8'h04, 8'h50, 8'h00);  // wraps below zero
        run("R11", 16'hFFFE, 8'h04, 8'h60, 8'h10); // not taken, pc wraps
    endtask

    task automatic t_bit3;
        rd_a = 8'h00;
        run("R7", 16'h5000, 8'h04, 8'h48, 8'h33);
        run("R7", 16'h5000, 8'h04, 8'h08, 8'h33);  // dec with bit 3 set
    endtask

    task automatic t_illegal;
        rd_a = 8'h00;
        run("R4", 16'h6000, 8'h04, 8'hC0, 8'h10);
        run("R2", 16'h6000, 8'h04, 8'h02, 8'h10);
        run("R2", 16'h6000, 8'h04, 8'h43, 8'h10);
        run("R1", 16'h6000, 8'h05, 8'h40, 8'h10);
    endtask

    // A second start while busy must not replace the first instruction.
    task automatic t_busy_ignore;
        @(negedge clk);
        pc_in = 16'h7000; opc_byte = 8'h04; ctl_byte = 8'h40; disp_byte = 8'h20;
        rd_a = 8'h00;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pc_in = 16'h7100; ctl_byte = 8'hC0;   // held start, new bytes
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R10", "busy ignore done", {31'd0, done}, 32'd1);
        chk("R10", "busy ignore pc", {16'd0, next_pc}, 32'h7023);
        chk("R10", "busy ignore illegal", {31'd0, illegal}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R10", "busy ignore idle", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_test_only();
        t_dec_inc();
        t_wrap8();
        t_offsets();
        t_bit3();
        t_illegal();
        t_busy_ignore();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule